// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block reprograms one of up to five integer-mode PLLs without letting any clock it feeds glitch. A request gives a PLL index and four divider values: reference divider, feedback divider and two post dividers. The block first checks these against the legal frequency windows, using a 24 MHz reference and kHz integer arithmetic. A shared sequential divider does the check over several cycles. Only a legal request ever touches a register.

A legal request takes the chosen PLL through a fixed sequence. The PLL's bit in the shared mode word drops to slow (bypass) mode. The integer-mode bit is forced on. The feedback and first post divider are written, then the reference and second post divider. The sequencer then waits for the PLL's lock flag. When lock arrives, the mode bit returns to normal and a one-cycle completion pulse is given. If lock does not arrive within a cycle limit given on a port, the sequencer stops with a timeout error and leaves the PLL in slow mode.

The mode word and the two control words of every PLL appear on output ports. Bit 10 of each second control word reflects that PLL's lock input live.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the mode word, all control words (lock bit aside), busy, done and both error flags read 0.
- R2: A request is legal only if 16 <= fbdiv <= 3200, VCO = 24000*fbdiv/refdiv kHz (integer) lies in [800000, 3200000], and VCO/(pd1*pd2) lies in [16000, 3200000] kHz. A zero divisor makes a request illegal. An illegal request sets err_illegal and changes no register.
- R3: A PLL's divider fields only ever change while its mode bit is 0 (slow). The mode bit positions for PLL indices 0,1,2,3,4 are 0,1,4,8,12.
- R4: The integer-mode bit (bit 12 of control word 1) is 1 before any divider field of that PLL changes.
- R5: Control word 0 holds fbdiv in [11:0] and pd1 in [14:12]. Control word 1 holds refdiv in [5:0] and pd2 in [8:6]. PLL k occupies bits [16k+15:16k] of each flattened output.
- R6: Bit 10 of control word 1 mirrors that PLL's lock input. The sequencer does not leave the wait state until that lock input is 1.
- R7: After lock, the mode bit returns to 1. done is high for exactly one cycle, in the first cycle the mode bit reads 1, and busy is low in that same cycle.
- R8: If lock is not seen within lock_limit_i cycles of waiting, err_timeout is set, busy drops, no done pulse occurs and the mode bit stays 0.
- R9: A request that arrives while busy is high is ignored entirely.
- R10: Registers of PLLs other than the selected one never change.
- R11: A PLL index of NPLL or more is illegal and is handled as in R2.
- R12: Both error flags clear when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, sampled when idle |
| req_pll_i | input | IDXW | Index of the PLL to reprogram |
| req_refdiv_i | input | 6 | Reference divider |
| req_fbdiv_i | input | 12 | Feedback divider |
| req_pd1_i | input | 3 | First post divider |
| req_pd2_i | input | 3 | Second post divider |
| lock_limit_i | input | TW | Cycles allowed in the lock wait |
| lock_i | input | NPLL | Lock flag of each PLL |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_illegal_o | output | 1 | Last request was rejected |
| err_timeout_o | output | 1 | Last request did not lock |
| mode_o | output | 16 | Shared mode word (1 = normal) |
| ctl0_o | output | NPLL*16 | Control word 0 of every PLL |
| ctl1_o | output | NPLL*16 | Control word 1 of every PLL, lock mirrored in bit 10 |

## Verification
The bench goes after the window edges. A VCO of exactly 3200 MHz must be accepted. VCOs of 3201 MHz and 720 MHz must be rejected. A feedback divider above 3200 with a legal VCO must be rejected; a design that ignored that cap would program it. An out-of-range PLL index is tried, which a design without the index guard would alias onto a real PLL. A lock that never comes exposes a design that falls through to normal mode or pulses done anyway. A request made during a running sequence shows whether the latched values get corrupted or a second sequence starts. A monitor watches for any divider change while a mode bit is set, which catches a sequence that writes dividers before entering slow mode.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   localparam int WORD_W      = 16;
   localparam int FB_W        = 12;
   localparam int REF_W       = 6;
   localparam int PD_W        = 3;
   localparam int PD1_LSB     = 12;
   localparam int PD2_LSB     = 6;
   localparam int LOCK_BIT    = 10;
   localparam int INTMODE_BIT = 12;
   localparam int MAX_PLL     = 5;

   typedef enum logic [2:0] {
      ST_IDLE, ST_CHECK, ST_SLOW, ST_INTMODE,
      ST_WR_FB, ST_WR_REF, ST_LOCKWAIT, ST_NORMAL
   } seq_state_t;

   typedef enum logic [1:0] {CK_IDLE, CK_VCO, CK_OUT} ck_state_t;

   // bit of the shared mode word owned by a PLL index
   function automatic int mode_pos(input int idx);
      case (idx)
         0:       return 0;
         1:       return 1;
         2:       return 4;
         3:       return 8;
         default: return 12;
      endcase
   endfunction

   function automatic logic [WORD_W-1:0] mode_mask(input int idx);
      return WORD_W'(1) << mode_pos(idx);
   endfunction

endpackage

// File: rtl/pll_seq_div.sv
// Restoring divider, one quotient bit per cycle.
module pll_seq_div #(
   parameter int W = 27
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         done_o,
   output logic [W-1:0] quo_o
);
   localparam int CW  = $clog2(W + 1);
   localparam int W2  = 2 * W;

   logic [W:0]    rem_q;
   logic [W-1:0]  q_q, den_q, num_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic [W:0]    shifted;
   logic          fits;

   assign shifted = {rem_q[W-1:0], q_q[W-1]};
   assign fits    = shifted >= {1'b0, den_q};
   assign quo_o   = q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         q_q    <= '0;
         den_q  <= '0;
         num_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            rem_q <= '0;
            q_q   <= num_i;
            num_q <= num_i;
            den_q <= den_i;
            cnt_q <= CW'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= fits ? (shifted - {1'b0, den_q}) : shifted;
            q_q   <= {q_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q  <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   // quotient never overshoots the dividend (feeds the R2 window check)
   p_quo_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (W2'(quo_o) * W2'(den_q) <= W2'(num_q)));
   p_div_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/pll_window_check.sv
module pll_window_check
   import pll_seq_pkg::*;
#(
   parameter int W           = 27,
   parameter int REF_KHZ     = 24000,
   parameter int VCO_MIN_KHZ = 800000,
   parameter int VCO_MAX_KHZ = 3200000,
   parameter int OUT_MIN_KHZ = 16000,
   parameter int OUT_MAX_KHZ = 3200000,
   parameter int FB_MIN      = 16,
   parameter int FB_MAX      = 3200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [FB_W-1:0]  fb_i,
   input  logic [REF_W-1:0] refdiv_i,
   input  logic [PD_W-1:0]  pd1_i,
   input  logic [PD_W-1:0]  pd2_i,
   output logic             done_o,
   output logic             legal_o
);
   localparam int PPW = 2 * PD_W;

   ck_state_t       ck_q;
   logic [FB_W-1:0] fb_q;
   logic [PPW-1:0]  pdp_q;
   logic [W-1:0]    vco_q;
   logic            div_start, div_done;
   logic [W-1:0]    div_num, div_den, div_quo;
   logic            fb_ok, vco_ok, out_ok;

   assign div_start = (ck_q == CK_IDLE && start_i) || (ck_q == CK_VCO && div_done);
   assign div_num   = (ck_q == CK_IDLE) ? W'(REF_KHZ) * W'(fb_i) : div_quo;
   assign div_den   = (ck_q == CK_IDLE) ? W'(refdiv_i) : W'(pdp_q);

   pll_seq_div #(.W(W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (div_start),
      .num_i   (div_num),
      .den_i   (div_den),
      .done_o  (div_done),
      .quo_o   (div_quo)
   );

   assign fb_ok  = (fb_q >= FB_W'(FB_MIN)) && (fb_q <= FB_W'(FB_MAX));
   assign vco_ok = (vco_q >= W'(VCO_MIN_KHZ)) && (vco_q <= W'(VCO_MAX_KHZ));
   assign out_ok = (div_quo >= W'(OUT_MIN_KHZ)) && (div_quo <= W'(OUT_MAX_KHZ));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_q    <= CK_IDLE;
         fb_q    <= '0;
         pdp_q   <= '0;
         vco_q   <= '0;
         done_o  <= 1'b0;
         legal_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (ck_q)
            CK_IDLE: if (start_i) begin
               fb_q  <= fb_i;
               pdp_q <= PPW'(pd1_i) * PPW'(pd2_i);
               ck_q  <= CK_VCO;
            end
            CK_VCO: if (div_done) begin
               vco_q <= div_quo;
               ck_q  <= CK_OUT;
            end
            CK_OUT: if (div_done) begin
               legal_o <= fb_ok && vco_ok && out_ok;
               done_o  <= 1'b1;
               ck_q    <= CK_IDLE;
            end
            default: ck_q <= CK_IDLE;
         endcase
      end
   end

   p_check_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/pll_lock_watch.sv
module pll_lock_watch #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm_i,
   input  logic          run_i,
   input  logic [TW-1:0] limit_i,
   output logic          expired_o
);
   logic [TW-1:0] cnt_q;

   assign expired_o = cnt_q >= limit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (arm_i)             cnt_q <= '0;
      else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
   end

   p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && $stable(limit_i) && !$past(arm_i)) |-> (cnt_q <= limit_i));

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
   import pll_seq_pkg::*;
#(
   parameter int NPLL        = 5,
   parameter int TW          = 16,
   parameter int REF_KHZ     = 24000,
   parameter int VCO_MIN_KHZ = 800000,
   parameter int VCO_MAX_KHZ = 3200000,
   parameter int OUT_MIN_KHZ = 16000,
   parameter int OUT_MAX_KHZ = 3200000,
   parameter int FB_MIN      = 16,
   parameter int FB_MAX      = 3200,
   localparam int IDXW       = (NPLL > 1) ? $clog2(NPLL + 1) : 1,
   localparam int QW         = $clog2(REF_KHZ) + FB_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_i,
   input  logic [IDXW-1:0]        req_pll_i,
   input  logic [REF_W-1:0]       req_refdiv_i,
   input  logic [FB_W-1:0]        req_fbdiv_i,
   input  logic [PD_W-1:0]        req_pd1_i,
   input  logic [PD_W-1:0]        req_pd2_i,
   input  logic [TW-1:0]          lock_limit_i,
   input  logic [NPLL-1:0]        lock_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic                   err_illegal_o,
   output logic                   err_timeout_o,
   output logic [WORD_W-1:0]      mode_o,
   output logic [NPLL*WORD_W-1:0] ctl0_o,
   output logic [NPLL*WORD_W-1:0] ctl1_o
);

   if (NPLL < 1 || NPLL > MAX_PLL) begin : g_bad_npll
      $error("NPLL must lie in 1..5");
   end
   if (QW > 31) begin : g_bad_qw
      $error("reference too large for the divider width");
   end

   seq_state_t        state_q;
   logic [IDXW-1:0]   pll_q;
   logic [REF_W-1:0]  refdiv_q;
   logic [FB_W-1:0]   fb_q;
   logic [PD_W-1:0]   pd1_q, pd2_q;
   logic [WORD_W-1:0] mask_q;
   logic [WORD_W-1:0] mode_q;
   logic              done_q, err_ill_q, err_to_q;
   logic [NPLL-1:0]   sel_oh;
   logic              accept, chk_done, chk_legal, expired, lock_sel, pll_ok;
   logic [WORD_W-1:0] ctl0_q [NPLL];
   logic [WORD_W-1:0] ctl1_q [NPLL];

   assign accept   = (state_q == ST_IDLE) && req_i;
   assign pll_ok   = 32'(pll_q) < NPLL;
   assign lock_sel = |(lock_i & sel_oh);

   pll_window_check #(
      .W(QW), .REF_KHZ(REF_KHZ),
      .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ),
      .OUT_MIN_KHZ(OUT_MIN_KHZ), .OUT_MAX_KHZ(OUT_MAX_KHZ),
      .FB_MIN(FB_MIN), .FB_MAX(FB_MAX)
   ) u_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (accept),
      .fb_i     (req_fbdiv_i),
      .refdiv_i (req_refdiv_i),
      .pd1_i    (req_pd1_i),
      .pd2_i    (req_pd2_i),
      .done_o   (chk_done),
      .legal_o  (chk_legal)
   );

   pll_lock_watch #(.TW(TW)) u_watch (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (state_q == ST_WR_REF),
      .run_i     (state_q == ST_LOCKWAIT),
      .limit_i   (lock_limit_i),
      .expired_o (expired)
   );

   // sequencing FSM and shared mode word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pll_q     <= '0;
         refdiv_q  <= '0;
         fb_q      <= '0;
         pd1_q     <= '0;
         pd2_q     <= '0;
         mask_q    <= '0;
         mode_q    <= '0;
         done_q    <= 1'b0;
         err_ill_q <= 1'b0;
         err_to_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (req_i) begin
               pll_q     <= req_pll_i;
               refdiv_q  <= req_refdiv_i;
               fb_q      <= req_fbdiv_i;
               pd1_q     <= req_pd1_i;
               pd2_q     <= req_pd2_i;
               mask_q    <= mode_mask(int'(req_pll_i));
               err_ill_q <= 1'b0;
               err_to_q  <= 1'b0;
               state_q   <= ST_CHECK;
            end
            ST_CHECK: if (chk_done) begin
               if (chk_legal && pll_ok) state_q <= ST_SLOW;
               else begin
                  err_ill_q <= 1'b1;
                  state_q   <= ST_IDLE;
               end
            end
            ST_SLOW: begin
               mode_q  <= mode_q & ~mask_q;
               state_q <= ST_INTMODE;
            end
            ST_INTMODE:  state_q <= ST_WR_FB;
            ST_WR_FB:    state_q <= ST_WR_REF;
            ST_WR_REF:   state_q <= ST_LOCKWAIT;
            ST_LOCKWAIT: begin
               if (lock_sel) state_q <= ST_NORMAL;
               else if (expired) begin
                  err_to_q <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
            ST_NORMAL: begin
               mode_q  <= mode_q | mask_q;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // per-PLL control words
   for (genvar k = 0; k < NPLL; k++) begin : g_pll
      assign sel_oh[k] = (32'(pll_q) == k);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl0_q[k] <= '0;
            ctl1_q[k] <= '0;
         end else if (sel_oh[k]) begin
            if (state_q == ST_INTMODE)
               ctl1_q[k][INTMODE_BIT] <= 1'b1;
            if (state_q == ST_WR_FB) begin
               ctl0_q[k][FB_W-1:0]              <= fb_q;
               ctl0_q[k][PD1_LSB +: PD_W]       <= pd1_q;
            end
            if (state_q == ST_WR_REF) begin
               ctl1_q[k][REF_W-1:0]             <= refdiv_q;
               ctl1_q[k][PD2_LSB +: PD_W]       <= pd2_q;
            end
         end
      end

      assign ctl0_o[k*WORD_W +: WORD_W] = ctl0_q[k];
      assign ctl1_o[k*WORD_W +: WORD_W] = ctl1_q[k] | (WORD_W'(lock_i[k]) << LOCK_BIT);

      p_slow_before_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!$stable(ctl0_q[k]) || !$stable(ctl1_q[k])) |-> !mode_q[mode_pos(k)]);
      p_intmode_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(ctl0_q[k]) |-> ctl1_q[k][INTMODE_BIT]);
      p_only_selected_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (!$stable(ctl0_q[k]) || !$stable(ctl1_q[k])) |-> $past(sel_oh[k]));
   end

   assign busy_o        = (state_q != ST_IDLE);
   assign done_o        = done_q;
   assign err_illegal_o = err_ill_q;
   assign err_timeout_o = err_to_q;
   assign mode_o        = mode_q;

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   p_done_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ((mode_q & mask_q) != '0) && !busy_o);
   p_normal_after_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(lock_sel, 2));
   p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_ill_q) |-> $stable(mode_q));
   p_timeout_slow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_to_q && state_q == ST_IDLE) |-> ((mode_q & mask_q) == '0));

endmodule

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;
   localparam int NP  = 5;
   localparam int DLY = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [2:0]  rq_pll = '0;
   logic [5:0]  rq_ref = '0;
   logic [11:0] rq_fb = '0;
   logic [2:0]  rq_pd1 = '0, rq_pd2 = '0;
   logic [15:0] limit = 16'd200;
   logic [4:0]  lock = '0;
   logic [4:0]  hold = '0;
   logic        busy, done, err_ill, err_to;
   logic [15:0] mode;
   logic [79:0] ctl0, ctl1;

   int checks = 0, errors = 0, done_seen = 0, slow_viol = 0;
   logic [15:0] m_ctl0 [NP];
   logic [15:0] m_ctl1 [NP];
   logic [15:0] m_mode = '0;
   logic [31:0] snap [NP];
   int          lcnt [NP];

   always #4 clk = ~clk;

   pll_reprog_seq u_pll_reprog_seq (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_pll_i(rq_pll),
      .req_refdiv_i(rq_ref), .req_fbdiv_i(rq_fb), .req_pd1_i(rq_pd1),
      .req_pd2_i(rq_pd2), .lock_limit_i(limit), .lock_i(lock),
      .busy_o(busy), .done_o(done), .err_illegal_o(err_ill),
      .err_timeout_o(err_to), .mode_o(mode), .ctl0_o(ctl0), .ctl1_o(ctl1)
   );

   function automatic int bpos(input int k);
      case (k) 0: return 0; 1: return 1; 2: return 4; 3: return 8; default: return 12; endcase
   endfunction

   function automatic logic [15:0] w0(input int k); return ctl0[k*16 +: 16]; endfunction
   function automatic logic [15:0] w1(input int k); return ctl1[k*16 +: 16] & ~16'h0400; endfunction

   // PLL lock model and monitors, all at the falling edge
   always @(negedge clk) begin
      for (int k = 0; k < NP; k++) begin
         if (!rst_n) begin
            lock[k] <= 1'b0; lcnt[k] = 0; snap[k] = '0;
         end else begin
            if ({w0(k), w1(k)} != snap[k]) begin
               if (mode[bpos(k)]) slow_viol++;
               lock[k] <= 1'b0; lcnt[k] = 0;
            end else if (hold[k]) lock[k] <= 1'b0;
            else if (lcnt[k] >= DLY) lock[k] <= 1'b1;
            else lcnt[k]++;
            snap[k] = {w0(k), w1(k)};
         end
      end
      if (rst_n && done) done_seen++;
   end

   task automatic chk(input string rq, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic bit legal(input int p, input int r, input int f, input int a, input int b);
      longint vco, o;
      if (p >= NP || r == 0 || a * b == 0) return 0;
      vco = longint'(24000) * f / r;
      o   = vco / (a * b);
      return f >= 16 && f <= 3200 && vco >= 800000 && vco <= 3200000 && o >= 16000 && o <= 3200000;
   endfunction

   task automatic issue(input int p, input int r, input int f, input int a, input int b);
      @(negedge clk);
      req = 1'b1; rq_pll = 3'(p); rq_ref = 6'(r); rq_fb = 12'(f); rq_pd1 = 3'(a); rq_pd2 = 3'(b);
      @(negedge clk);
      req = 1'b0;
      for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_all(input string rq);
      for (int k = 0; k < NP; k++) begin
         chk(rq, "ctl0 word", w0(k), m_ctl0[k]);
         chk(rq, "ctl1 word", w1(k), m_ctl1[k]);
      end
      chk(rq, "mode word", mode, m_mode);
   endtask

   task automatic t_reset;
      chk("R1", "mode", mode, 0);
      chk("R1", "ctl0", ctl0, 0);
      chk("R1", "ctl1 no lock", ctl1 & {5{16'hFBFF}}, 0);
      chk("R1", "flags", {busy, done, err_ill, err_to}, 0);
   endtask

   task automatic t_legal(input int p, input int r, input int f, input int a, input int b);
      int d0 = done_seen;
      chk("R2", "model says legal", legal(p, r, f, a, b), 1);
      issue(p, r, f, a, b);
      m_ctl0[p] = 16'(f) | (16'(a) << 12);
      m_ctl1[p] = 16'(r) | (16'(b) << 6) | 16'h1000;
      m_mode    = m_mode | (16'd1 << bpos(p));
      chk("R5", "fields", {w0(p), w1(p)}, {m_ctl0[p], m_ctl1[p]});
      chk("R4", "integer-mode bit", ctl1[p*16 + 12], 1);
      chk("R6", "lock mirrored", ctl1[p*16 + 10], 1);
      chk("R7", "done pulses", done_seen - d0, 1);
      chk("R3", "mode bit normal", mode[bpos(p)], 1);
      chk("R3", "no divider change in normal", slow_viol, 0);
      chk("R12", "errors clear", {err_ill, err_to}, 0);
      check_all("R10");
   endtask

   task automatic t_illegal(input string rq, input int p, input int r, input int f, input int a, input int b);
      int d0 = done_seen;
      chk(rq, "model says illegal", legal(p, r, f, a, b), 0);
      issue(p, r, f, a, b);
      chk(rq, "err_illegal", err_ill, 1);
      chk(rq, "no done", done_seen - d0, 0);
      check_all("R2");
   endtask

   task automatic t_timeout;
      int d0 = done_seen;
      hold[2] = 1'b1; limit = 16'd20;
      issue(2, 1, 45, 2, 2);
      m_ctl0[2] = 16'd45 | (16'd2 << 12);
      m_ctl1[2] = 16'd1 | (16'd2 << 6) | 16'h1000;
      m_mode    = m_mode & ~(16'd1 << 4);
      chk("R8", "err_timeout", err_to, 1);
      chk("R8", "no done", done_seen - d0, 0);
      chk("R8", "mode stays slow", mode[4], 0);
      chk("R6", "lock bit low", ctl1[2*16 + 10], 0);
      check_all("R8");
      hold[2] = 1'b0; limit = 16'd200;
   endtask

   task automatic t_busy_ignore;
      int d0 = done_seen;
      @(negedge clk);
      req = 1'b1; rq_pll = 3'd3; rq_ref = 6'd3; rq_fb = 12'd150; rq_pd1 = 3'd3; rq_pd2 = 3'd2;
      @(negedge clk);
      req = 1'b0;
      repeat (70) @(negedge clk);
      req = 1'b1; rq_pll = 3'd0; rq_ref = 6'd1; rq_fb = 12'd40; rq_pd1 = 3'd1; rq_pd2 = 3'd1;
      @(negedge clk);
      req = 1'b0;
      for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R9", "still idle after", busy, 0);
      chk("R9", "one done only", done_seen - d0, 1);
      m_ctl0[3] = 16'd150 | (16'd3 << 12);
      m_ctl1[3] = 16'd3 | (16'd2 << 6) | 16'h1000;
      check_all("R9");
   endtask

   initial begin
      for (int k = 0; k < NP; k++) begin m_ctl0[k] = '0; m_ctl1[k] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_legal(4, 1, 50, 4, 1);
      t_legal(3, 2, 100, 2, 1);
      t_legal(0, 1, 68, 2, 1);
      t_legal(1, 24, 3200, 1, 1);    // VCO exactly at upper edge
      t_illegal("R2", 2, 1, 30, 2, 1);    // VCO 720 MHz
      t_illegal("R2", 1, 24, 3201, 1, 1); // VCO 3201 MHz
      t_illegal("R2", 0, 30, 3300, 2, 1); // fbdiv above cap, VCO legal
      t_illegal("R2", 3, 0, 50, 2, 1);    // zero reference divider
      t_illegal("R11", 5, 1, 50, 4, 1);
      t_timeout();
      t_legal(2, 1, 45, 2, 2);       // recovers after timeout
      t_busy_ignore();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog run hung actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule